// File: doc/BRIEF.md
# Processor bus cycle type decoder

This block watches the cycle-definition pins of a processor bus and turns them into one-hot cycle strobes for the rest of the board. It uses five qualifiers: memory-versus-I/O, data-versus-code, write-versus-read, the processor's cacheability hint and the system's cache-enable reply. These pins mean something only on the clock where the address strobe is low, so the block captures them on that edge and nowhere else.

From the captured values it raises one of eight type strobes: interrupt acknowledge, special cycle, I/O read, I/O write, code fetch, memory read, memory write, or invalid. It also gives a burst qualifier and the number of data transfers the cycle will carry. Everything stays held until the board pulses cycle-done. Chip-select logic downstream reads the held strobes.

Top module: `cyc_type_decoder`

## Requirements
- R1: The qualifier inputs are captured only on a rising clock edge where `ads_n` is 0. The outputs show the new decode from that edge on. A capture replaces any decode still held.
- R2: When `mem_io_n`=0 and `cache_n`=1, the pair {`data_code_n`,`wr_rd_n`} selects the strobe: 00 gives `stb_inta`, 01 gives `stb_special`, 10 gives `stb_io_rd` and 11 gives `stb_io_wr`.
- R3: When `mem_io_n`=1, the pair {`data_code_n`,`wr_rd_n`} selects the strobe: 00 gives `stb_code_rd`, 10 gives `stb_mem_rd`, 11 gives `stb_mem_wr`, and 01 (a reserved code) gives `stb_invalid`.
- R4: A capture with `mem_io_n`=0 and `cache_n`=0 raises `stb_invalid` alone, whatever the other inputs are.
- R5: `burst` is 1 for a code fetch or memory read with `cache_n`=0 and `ken_n`=0, and for a memory write with `cache_n`=0. It is 0 in every other case. `xfer_cnt` is 4 when `burst` is 1, 1 for any other captured cycle, and 0 when no cycle is held.
- R6: From a capture until it is cleared, exactly one of the eight type strobes is 1. While `ads_n` is 1 and `cycle_done` is 0, the strobes, `burst` and `xfer_cnt` keep their values, whatever the qualifier inputs do.
- R7: A rising edge with `cycle_done`=1 and `ads_n`=1 clears every strobe, `burst` and `xfer_cnt`. If `cycle_done`=1 and `ads_n`=0 on the same edge, the new capture wins.
- R8: A rising edge with `rst`=1 clears every strobe, `burst` and `xfer_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe, active low |
| mem_io_n | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| data_code_n | input | 1 | 1 = data, 0 = code |
| wr_rd_n | input | 1 | 1 = write, 0 = read |
| cache_n | input | 1 | Processor cacheability hint, active low |
| ken_n | input | 1 | System cache-enable reply, active low |
| cycle_done | input | 1 | Current cycle has ended; clears the held decode |
| stb_inta | output | 1 | Interrupt acknowledge |
| stb_special | output | 1 | Special cycle |
| stb_io_rd | output | 1 | I/O read |
| stb_io_wr | output | 1 | I/O write |
| stb_code_rd | output | 1 | Code fetch |
| stb_mem_rd | output | 1 | Memory read |
| stb_mem_wr | output | 1 | Memory write |
| stb_invalid | output | 1 | Reserved or inconsistent cycle definition |
| burst | output | 1 | Line fill or writeback burst |
| xfer_cnt | output | 3 | Expected data transfers: 0 idle, 1 or 4 |

## Verification
Each result is due one clock edge after its cause. A capture appears at the edge where `ads_n` is low, and a clear appears at the edge where `cycle_done` or `rst` is high. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so every check falls half a period after the edge that should have changed the result. The bench sweeps all 32 qualifier combinations. For each one it checks the captured decode, checks that the held decode survives scrambled inputs while `ads_n` is high, and checks that the clear arrives on the `cycle_done` edge.

// File: rtl/cycdec_pkg.sv
package cycdec_pkg;

    typedef enum logic [3:0] {
        CK_NONE    = 4'd0,
        CK_INTA    = 4'd1,
        CK_SPECIAL = 4'd2,
        CK_IO_RD   = 4'd3,
        CK_IO_WR   = 4'd4,
        CK_CODE_RD = 4'd5,
        CK_MEM_RD  = 4'd6,
        CK_MEM_WR  = 4'd7,
        CK_INVALID = 4'd8
    } cyc_kind_e;

    localparam int unsigned NUM_KINDS = 8;

    typedef struct packed {
        logic mem_io_n;
        logic data_code_n;
        logic wr_rd_n;
        logic cache_n;
        logic ken_n;
    } cyc_def_t;

    typedef struct packed {
        cyc_kind_e kind;
        logic      burst;
    } cyc_dec_t;

    function automatic cyc_dec_t classify(input cyc_def_t d);
        cyc_dec_t r;
        r.burst = 1'b0;
        if (!d.mem_io_n) begin
            if (!d.cache_n) begin
                r.kind = CK_INVALID;
            end else begin
                unique case ({d.data_code_n, d.wr_rd_n})
                    2'b00:   r.kind = CK_INTA;
                    2'b01:   r.kind = CK_SPECIAL;
                    2'b10:   r.kind = CK_IO_RD;
                    default: r.kind = CK_IO_WR;
                endcase
            end
        end else begin
            unique case ({d.data_code_n, d.wr_rd_n})
                2'b00: begin
                    r.kind  = CK_CODE_RD;
                    r.burst = !d.cache_n && !d.ken_n;
                end
                2'b01: r.kind = CK_INVALID;
                2'b10: begin
                    r.kind  = CK_MEM_RD;
                    r.burst = !d.cache_n && !d.ken_n;
                end
                default: begin
                    r.kind  = CK_MEM_WR;
                    r.burst = !d.cache_n;
                end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/cycdec_decode.sv
module cycdec_decode
    import cycdec_pkg::*;
#(
    parameter int unsigned BURST_XFERS = 4,
    parameter int unsigned CNT_W       = 3
) (
    input  cyc_def_t         def_i,
    output cyc_dec_t         dec_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_BURST  = CNT_W'(BURST_XFERS);
    localparam logic [CNT_W-1:0] CNT_SINGLE = CNT_W'(1);

    always_comb begin
        dec_o = classify(def_i);
        cnt_o = dec_o.burst ? CNT_BURST : CNT_SINGLE;
    end
endmodule

// File: rtl/cycdec_hold.sv
module cycdec_hold
    import cycdec_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_i,
    input  logic             clear_i,
    input  cyc_dec_t         dec_i,
    input  logic [CNT_W-1:0] cnt_i,
    output cyc_dec_t         dec_q,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '{kind: CK_NONE, burst: 1'b0};
            cnt_q <= '0;
        end else if (capture_i) begin
            dec_q <= dec_i;
            cnt_q <= cnt_i;
        end else if (clear_i) begin
            dec_q <= '{kind: CK_NONE, burst: 1'b0};
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/cyc_type_decoder.sv
module cyc_type_decoder
    import cycdec_pkg::*;
#(
    parameter int unsigned BURST_XFERS = 4,
    localparam int unsigned CNT_W      = $clog2(BURST_XFERS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ads_n,
    input  logic             mem_io_n,
    input  logic             data_code_n,
    input  logic             wr_rd_n,
    input  logic             cache_n,
    input  logic             ken_n,
    input  logic             cycle_done,
    output logic             stb_inta,
    output logic             stb_special,
    output logic             stb_io_rd,
    output logic             stb_io_wr,
    output logic             stb_code_rd,
    output logic             stb_mem_rd,
    output logic             stb_mem_wr,
    output logic             stb_invalid,
    output logic             burst,
    output logic [CNT_W-1:0] xfer_cnt
);
    cyc_def_t         def_w;
    cyc_dec_t         dec_w;
    cyc_dec_t         dec_q;
    logic [CNT_W-1:0] cnt_w;
    logic [NUM_KINDS:1] stb_vec;

    assign def_w = '{mem_io_n: mem_io_n, data_code_n: data_code_n,
                     wr_rd_n: wr_rd_n, cache_n: cache_n, ken_n: ken_n};

    cycdec_decode #(.BURST_XFERS(BURST_XFERS), .CNT_W(CNT_W)) u_decode (
        .def_i (def_w),
        .dec_o (dec_w),
        .cnt_o (cnt_w)
    );

    cycdec_hold #(.CNT_W(CNT_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .capture_i (!ads_n),
        .clear_i   (cycle_done),
        .dec_i     (dec_w),
        .cnt_i     (cnt_w),
        .dec_q     (dec_q),
        .cnt_q     (xfer_cnt)
    );

    for (genvar k = 1; k <= NUM_KINDS; k++) begin : g_stb
        assign stb_vec[k] = (dec_q.kind == cyc_kind_e'(k));
    end

    assign stb_inta    = stb_vec[CK_INTA];
    assign stb_special = stb_vec[CK_SPECIAL];
    assign stb_io_rd   = stb_vec[CK_IO_RD];
    assign stb_io_wr   = stb_vec[CK_IO_WR];
    assign stb_code_rd = stb_vec[CK_CODE_RD];
    assign stb_mem_rd  = stb_vec[CK_MEM_RD];
    assign stb_mem_wr  = stb_vec[CK_MEM_WR];
    assign stb_invalid = stb_vec[CK_INVALID];
    assign burst       = dec_q.burst;
endmodule

// File: rtl/cyc_type_decoder_chk.sv
module cyc_type_decoder_chk #(
    parameter int unsigned BURST_XFERS = 4,
    parameter int unsigned CNT_W       = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ads_n,
    input logic             mem_io_n,
    input logic             cache_n,
    input logic             cycle_done,
    input logic [7:0]       stbs,
    input logic             burst,
    input logic [CNT_W-1:0] xfer_cnt
);
    // R6: never more than one type strobe
    p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stbs));

    // R1: a capture always leaves exactly one strobe high
    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        !ads_n |=> $countones(stbs) == 1);

    // R4: I/O cycle carrying the cacheability hint is flagged invalid
    p_io_cache_r4: assert property (@(posedge clk) disable iff (rst)
        (!ads_n && !mem_io_n && !cache_n) |=> stbs[0]);

    // R6: held state is stable between strobes
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ads_n && !cycle_done) |=> ($stable(stbs) && $stable(burst) && $stable(xfer_cnt)));

    // R7: done without a new strobe clears everything
    p_done_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (ads_n && cycle_done) |=> (stbs == 8'd0 && !burst && xfer_cnt == '0));

    // R5: transfer count agrees with the burst qualifier
    p_count_r5: assert property (@(posedge clk) disable iff (rst)
        burst |-> (xfer_cnt == CNT_W'(BURST_XFERS) && stbs != 8'd0));

    // R8: reset clears the decode
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (stbs == 8'd0 && !burst && xfer_cnt == '0));
endmodule

bind cyc_type_decoder cyc_type_decoder_chk #(
    .BURST_XFERS (BURST_XFERS),
    .CNT_W       (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ads_n      (ads_n),
    .mem_io_n   (mem_io_n),
    .cache_n    (cache_n),
    .cycle_done (cycle_done),
    .stbs       ({stb_inta, stb_special, stb_io_rd, stb_io_wr,
                  stb_code_rd, stb_mem_rd, stb_mem_wr, stb_invalid}),
    .burst      (burst),
    .xfer_cnt   (xfer_cnt)
);

// File: tb/cyc_type_decoder_test.sv
`timescale 1ns/1ps
module cyc_type_decoder_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ads_n = 1'b1, mem_io_n = 1'b0, data_code_n = 1'b0, wr_rd_n = 1'b0;
    logic cache_n = 1'b1, ken_n = 1'b1, cycle_done = 1'b0;
    logic stb_inta, stb_special, stb_io_rd, stb_io_wr;
    logic stb_code_rd, stb_mem_rd, stb_mem_wr, stb_invalid, burst;
    logic [2:0] xfer_cnt;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cyc_type_decoder uut (
        .clk(clk), .rst(rst), .ads_n(ads_n), .mem_io_n(mem_io_n),
        .data_code_n(data_code_n), .wr_rd_n(wr_rd_n), .cache_n(cache_n),
        .ken_n(ken_n), .cycle_done(cycle_done),
        .stb_inta(stb_inta), .stb_special(stb_special), .stb_io_rd(stb_io_rd),
        .stb_io_wr(stb_io_wr), .stb_code_rd(stb_code_rd), .stb_mem_rd(stb_mem_rd),
        .stb_mem_wr(stb_mem_wr), .stb_invalid(stb_invalid), .burst(burst),
        .xfer_cnt(xfer_cnt)
    );

    // packed observed result: {8 strobes (inta..invalid), burst, count}
    function automatic logic [11:0] observed();
        return {stb_inta, stb_special, stb_io_rd, stb_io_wr, stb_code_rd,
                stb_mem_rd, stb_mem_wr, stb_invalid, burst, xfer_cnt};
    endfunction

    // expected result for combination idx = {mem_io_n,data_code_n,wr_rd_n,cache_n,ken_n}
    function automatic logic [11:0] expected(input int idx);
        logic m = idx[4], d = idx[3], w = idx[2], c = idx[1], k = idx[0];
        logic [7:0] s = 8'd0;
        logic b = 1'b0;
        int pos;
        if (!m && !c) s[0] = 1'b1;                   // R4
        else if (!m) begin                           // R2
            pos = 7 - (d ? 2 : 0) - (w ? 1 : 0);
            s[pos] = 1'b1;
        end else if (!d && w) s[0] = 1'b1;           // R3 reserved
        else begin                                   // R3 memory kinds
            if (!d) s[3] = 1'b1;
            else if (!w) s[2] = 1'b1;
            else s[1] = 1'b1;
            b = w ? !c : (!c && !k);                 // R5
        end
        return {s, b, b ? 3'd4 : 3'd1};
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive_def(input int idx);
        {mem_io_n, data_code_n, wr_rd_n, cache_n, ken_n} = 5'(idx);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset state", observed(), 12'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R6 idle after reset", observed(), 12'd0);

        for (int i = 0; i < 32; i++) begin
            drive_def(i);
            ads_n = 1'b0;
            @(negedge clk);
            ads_n = 1'b1;
            check($sformatf("R1/R2/R3/R4/R5 capture combo %0d", i), observed(), expected(i));
            drive_def(31 - i);
            @(negedge clk);
            drive_def((i * 7 + 3) % 32);
            @(negedge clk);
            check($sformatf("R6 held with ads high combo %0d", i), observed(), expected(i));
            cycle_done = 1'b1;
            @(negedge clk);
            cycle_done = 1'b0;
            check($sformatf("R7 cleared by done combo %0d", i), observed(), 12'd0);
        end

        // back-to-back captures: second replaces first (R1)
        drive_def(5'b11000); ads_n = 1'b0; @(negedge clk);
        drive_def(5'b01111); @(negedge clk);
        ads_n = 1'b1;
        check("R1 second capture replaces first", observed(), expected(5'b01111));

        // capture and done on the same edge: capture wins (R7)
        drive_def(5'b10000); ads_n = 1'b0; cycle_done = 1'b1; @(negedge clk);
        ads_n = 1'b1; cycle_done = 1'b0;
        check("R7 capture beats done", observed(), expected(5'b10000));

        // reset while a cycle is held (R8)
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R8 reset clears held cycle", observed(), 12'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule